// File: doc/BRIEF.md
# Single-Step Shift/Rotate Unit

This block is the shift and rotate stage of a small I/O processor's datapath. It receives one register value, a three-bit operation select, a three-bit count field and the index of the register the value came from. When the enable is raised, the unit computes the shifted or rotated value and registers it, together with the register index and a one-cycle write strobe, so the register file can store the result back into that same register on the following cycle.

Six operations are provided: logical shifts in both directions, arithmetic shifts in both directions and rotates in both directions. Every operation moves the value by exactly one bit position, whatever the count field holds. The right arithmetic shift fills the vacated top bit with a constant 1 by default. Shifts and rotates never change the condition-code zero bit, so a flag-update output is provided and is held low at all times. Two operation codes are reserved and return the value unchanged.

Top module: `ssru_top`

## Requirements
- R1: While reset (active low) is held and in the first cycle after it, `wr_en` is 0, `result` is 0 and `wr_addr` is 0.
- R2: Operation code 0 (logical left) returns the value moved up one bit with 0 entering bit 0.
- R3: Operation code 1 (logical right) returns the value moved down one bit with 0 entering the top bit.
- R4: Operation code 2 (arithmetic left) returns the same value as operation code 0 for every input.
- R5: Operation code 3 (arithmetic right) returns the value moved down one bit with 1 entering the top bit, whatever the old top bit was.
- R6: Operation code 4 (rotate left) returns the value moved up one bit with the old top bit entering bit 0.
- R7: Operation code 5 (rotate right) returns the value moved down one bit with the old bit 0 entering the top bit.
- R8: Operation codes 6 and 7 return the input value unchanged.
- R9: The count field has no effect: counts 0 through 7 all give a one-position result.
- R10: `wr_en` is high for exactly the one cycle after each cycle in which `en` was sampled high, and `result` and `wr_addr` show that operation's value and source register index in that cycle; when `en` is low, `result` and `wr_addr` keep their previous values.
- R11: `flag_upd` is 0 in every cycle, so no operation touches the zero flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Reset, active low, synchronous |
| en | input | 1 | Start one operation this cycle |
| op | input | 3 | Operation select, codes 0 to 7 |
| cnt | input | 3 | Count field from the instruction, ignored |
| src_data | input | W (8) | Value read from the source register |
| src_addr | input | AW (3) | Index of the source register |
| result | output | W (8) | Registered shifted or rotated value |
| wr_addr | output | AW (3) | Destination register index (same as source) |
| wr_en | output | 1 | One-cycle write strobe for the register file |
| flag_upd | output | 1 | Zero-flag update request, always 0 |

## Verification
The assertions assume that `en`, `op`, `src_data` and `src_addr` are stable and known at each rising edge and that `en` is held low while reset is asserted, so each property only has to relate one sampled operation to the next cycle's outputs. The stimulus is driven on the falling edge, keeps `en` low through reset, and walks every operation code against every count value with edge patterns (all zeros, all ones, single top bit, single bottom bit) and pseudo-random data, with idle gaps between enables to exercise the hold behaviour.

// File: rtl/ssru_pkg.sv
package ssru_pkg;
   typedef enum logic [2:0] {
      OP_SHL_LOG = 3'd0,
      OP_SHR_LOG = 3'd1,
      OP_SHL_ARI = 3'd2,
      OP_SHR_ARI = 3'd3,
      OP_ROT_L   = 3'd4,
      OP_ROT_R   = 3'd5,
      OP_RSV_A   = 3'd6,
      OP_RSV_B   = 3'd7
   } shift_op_e;

   localparam int unsigned OP_BITS  = 3;
   localparam int unsigned CNT_BITS = 3;
endpackage

// File: rtl/ssru_core.sv
module ssru_core
   import ssru_pkg::*;
#(
   parameter int unsigned W        = 8,
   parameter bit          SAR_ONES = 1'b1
) (
   input  logic [W-1:0]       din,
   input  logic [OP_BITS-1:0] op,
   output logic [W-1:0]       dout
);
   localparam int unsigned MSB = W - 1;

   generate
      if (W < 2) begin : g_bad_width
         $error("ssru_core: W must be at least 2");
      end
   endgenerate

   logic sar_fill;

   generate
      if (SAR_ONES) begin : g_fill_one
         assign sar_fill = 1'b1;
      end else begin : g_fill_sign
         assign sar_fill = din[MSB];
      end
   endgenerate

   shift_op_e op_e;
   assign op_e = shift_op_e'(op);

   always_comb begin
      unique case (op_e)
         OP_SHL_LOG,
         OP_SHL_ARI: dout = {din[MSB-1:0], 1'b0};
         OP_SHR_LOG: dout = {1'b0, din[MSB:1]};
         OP_SHR_ARI: dout = {sar_fill, din[MSB:1]};
         OP_ROT_L:   dout = {din[MSB-1:0], din[MSB]};
         OP_ROT_R:   dout = {din[0], din[MSB:1]};
         default:    dout = din;
      endcase
   end
endmodule

// File: rtl/ssru_wb_reg.sv
module ssru_wb_reg #(
   parameter int unsigned W  = 8,
   parameter int unsigned AW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [W-1:0]  nxt_data,
   input  logic [AW-1:0] nxt_addr,
   output logic [W-1:0]  q_data,
   output logic [AW-1:0] q_addr,
   output logic          q_strobe
);
   generate
      if (AW < 1) begin : g_bad_aw
         $error("ssru_wb_reg: AW must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_data   <= '0;
         q_addr   <= '0;
         q_strobe <= 1'b0;
      end else begin
         q_strobe <= load;
         if (load) begin
            q_data <= nxt_data;
            q_addr <= nxt_addr;
         end
      end
   end
endmodule

// File: rtl/ssru_top.sv
module ssru_top
   import ssru_pkg::*;
#(
   parameter int unsigned W        = 8,
   parameter int unsigned AW       = 3,
   parameter bit          SAR_ONES = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic [OP_BITS-1:0]  op,
   input  logic [CNT_BITS-1:0] cnt,
   input  logic [W-1:0]        src_data,
   input  logic [AW-1:0]       src_addr,
   output logic [W-1:0]        result,
   output logic [AW-1:0]       wr_addr,
   output logic                wr_en,
   output logic                flag_upd
);
   // Every count value selects a single-position step; the field is accepted
   // for instruction compatibility only.
   logic unused_cnt;
   assign unused_cnt = ^cnt;

   logic [W-1:0] step_val;

   ssru_core #(.W(W), .SAR_ONES(SAR_ONES)) u_core (
      .din  (src_data),
      .op   (op),
      .dout (step_val)
   );

   ssru_wb_reg #(.W(W), .AW(AW)) u_wb (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (en),
      .nxt_data (step_val),
      .nxt_addr (src_addr),
      .q_data   (result),
      .q_addr   (wr_addr),
      .q_strobe (wr_en)
   );

   assign flag_upd = 1'b0;
endmodule

// File: rtl/ssru_chk.sv
module ssru_chk #(
   parameter int unsigned W  = 8,
   parameter int unsigned AW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          en,
   input logic [2:0]    op,
   input logic [W-1:0]  src_data,
   input logic [AW-1:0] src_addr,
   input logic [W-1:0]  result,
   input logic [AW-1:0] wr_addr,
   input logic          wr_en,
   input logic          flag_upd
);
   p_strobe_after_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> wr_en);
   p_no_strobe_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !wr_en);
   p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(result) && $stable(wr_addr)));
   p_addr_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (wr_addr == $past(src_addr)));
   p_sar_top_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && op == 3'd3) |=> result[W-1]);
   p_shl_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (op == 3'd0 || op == 3'd2)) |=> !result[0]);
   p_rotl_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && op == 3'd4) |=> (result[0] == $past(src_data[W-1])));
   p_rotr_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && op == 3'd5) |=> (result[W-1] == $past(src_data[0])));
   p_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && op[2:1] == 2'b11) |=> (result == $past(src_data)));
   p_flag_low_r11: assert property (@(posedge clk) !flag_upd);
endmodule

bind ssru_top ssru_chk #(.W(W), .AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en       (en),
   .op       (op),
   .src_data (src_data),
   .src_addr (src_addr),
   .result   (result),
   .wr_addr  (wr_addr),
   .wr_en    (wr_en),
   .flag_upd (flag_upd)
);

// File: tb/sim_ssru_top.sv
`timescale 1ns/1ps
module sim_ssru_top;
   localparam int W  = 8;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic [2:0]    op = '0;
   logic [2:0]    cnt = '0;
   logic [W-1:0]  src_data = '0;
   logic [AW-1:0] src_addr = '0;
   logic [W-1:0]  result;
   logic [AW-1:0] wr_addr;
   logic          wr_en;
   logic          flag_upd;

   always #2 clk = ~clk;

   ssru_top u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .op(op), .cnt(cnt),
      .src_data(src_data), .src_addr(src_addr),
      .result(result), .wr_addr(wr_addr), .wr_en(wr_en), .flag_upd(flag_upd)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit live = 1'b0;
   bit done = 1'b0;

   // Behavioural reference of one step, from the requirements.
   function automatic int ref_step(input int code, input int d);
      int r;
      case (code)
         0, 2: r = (d * 2) % 256;
         1:    r = d / 2;
         3:    r = (d / 2) + 128;
         4:    r = ((d * 2) % 256) + (d / 128);
         5:    r = (d / 2) + ((d % 2) * 128);
         default: r = d;
      endcase
      return r;
   endfunction

   function automatic string tag_of(input int code, input int c);
      string t;
      case (code)
         0: t = "R2"; 1: t = "R3"; 2: t = "R4"; 3: t = "R5";
         4: t = "R6"; 5: t = "R7"; default: t = "R8";
      endcase
      if (c != 1) t = {t, "/R9"};
      return t;
   endfunction

   int    m_res = 0;
   int    m_addr = 0;
   int    m_wr = 0;
   string m_tag = "R1";

   always @(posedge clk) begin
      if (!rst_n) begin
         m_res <= 0; m_addr <= 0; m_wr <= 0; m_tag <= "R1";
      end else begin
         m_wr <= en ? 1 : 0;
         if (en) begin
            m_res  <= ref_step(int'(op), int'(src_data));
            m_addr <= int'(src_addr);
            m_tag  <= tag_of(int'(op), int'(cnt));
         end else begin
            m_tag <= "R10";
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (live && !done) begin
         chk(m_tag, int'(result), m_res);
         chk("R10", int'(wr_en), m_wr);
         chk("R10", int'(wr_addr), m_addr);
         chk("R11", int'(flag_upd), 0);
      end
   end

   task automatic issue(input int o, input int c, input int d, input int a);
      @(negedge clk);
      en = 1'b1; op = 3'(o); cnt = 3'(c); src_data = 8'(d); src_addr = 3'(a);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         en = 1'b0; src_data = 8'($urandom); op = 3'($urandom); src_addr = 3'($urandom);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, 100000);
      finish_up();
   end

   initial begin
      int pats[6] = '{0, 255, 128, 1, 165, 90};
      // R1: reset state while reset is held
      repeat (3) @(negedge clk);
      chk("R1", int'(wr_en), 0);
      chk("R1", int'(result), 0);
      chk("R1", int'(wr_addr), 0);
      chk("R11", int'(flag_upd), 0);
      rst_n = 1'b1;
      live = 1'b1;
      idle(1);
      // R2..R9: every code, every count, edge patterns
      for (int o = 0; o < 8; o++) begin
         for (int c = 0; c < 8; c++) begin
            for (int p = 0; p < 6; p++) begin
               issue(o, c, pats[p], (o + p) % 8);
            end
         end
         idle(2);
      end
      // Random data, mixed enable density to exercise R10 hold
      for (int k = 0; k < 600; k++) begin
         if ($urandom_range(0, 2) == 0) idle(1);
         else issue($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 255), $urandom_range(0, 7));
      end
      idle(3);
      finish_up();
   end
endmodule